// File: doc/BRIEF.md
# Converter Self-Calibration Sequencer

This block decides when a converter's self-calibration runs and tells the rest of the chip that it is running. After reset it waits out a power-up delay and then runs a calibration. The delay is short or long depending on a select input, and it is always short when extended control is active. Once that first calibration finishes, a new one can be requested in two ways. The first is a qualified pulse on the calibration pin: a low period of a minimum length followed by a high period of a minimum length. The second is a write that sets the calibration bit of the control register at address `CAL_ADDR`.

A calibration is modelled as two fixed-length phases. The termination-trim phase lasts `TRIM_LEN` cycles, and the data clock forwarded off-chip is stopped while it runs. The core phase lasts `CAL_LEN` cycles. The power-up calibration always includes the trim phase. A later calibration skips the trim phase when the trim-disable input is high, so the data clock keeps running throughout.

Top module: `cal_sequencer`

## Requirements
- R1: Pin trigger qualification.
  - A calibration starts from the pin only when its synchronised level has been low for at least `LOW_MIN` consecutive cycles and then high for `HIGH_MIN` cycles. A shorter low run or a shorter high run starts nothing.
  - Once the pin has been low long enough, let edge P be the first clock edge that samples it high. `cal_run_o` is still low after edge P+HIGH_MIN+1 and is high after edge P+HIGH_MIN+2.
- R2: Register trigger.
  - A cycle with `reg_we_i`=1, `reg_addr_i`=`CAL_ADDR` and `reg_cal_i`=1, while the block is idle, sets `cal_bit_o` after that edge.
  - Calibration starts at the next edge.
  - A write to any other address has no effect.
- R3: `cal_run_o` stays high for the whole sequence: `TRIM_LEN`+`CAL_LEN` cycles when the trim phase runs, and `CAL_LEN` cycles when it is skipped.
- R4: With `ext_mode_i`=0, calibration starts after edge `DLY_SHORT` counted from reset release when `dly_sel_i`=0, and after edge `DLY_LONG` when `dly_sel_i`=1.
- R5: With `ext_mode_i`=1, the power-up delay is `DLY_SHORT` whatever the level of `dly_sel_i`.
- R6: `trim_phase_o` is high for the first `TRIM_LEN` cycles of a trimming sequence. `dclk_en_o` is low in exactly those cycles and high at all other times.
- R7: An on-command calibration with `trim_dis_i`=1 skips the trim phase. `dclk_en_o` stays high for the whole of it.
- R8: The power-up calibration always runs the trim phase, even when `trim_dis_i`=1.
- R9: `cal_bit_o` clears itself in the same edge that starts the sequence.
- R10: Requests that arrive while a calibration is running are discarded.
  - A register write leaves `cal_bit_o` at 0.
  - A pin pulse leaves no pending start.
- R11: While reset is asserted: `cal_run_o`=0, `trim_phase_o`=0, `dclk_en_o`=1 and `cal_bit_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Converter input clock |
| rst_ni | input | 1 | Asynchronous active-low reset (power-up) |
| cal_pin_i | input | 1 | Calibration request pin, asynchronous |
| reg_we_i | input | 1 | Control register write strobe |
| reg_addr_i | input | ADDR_W | Control register address |
| reg_cal_i | input | 1 | Calibration bit value written |
| dly_sel_i | input | 1 | Power-up delay select (1 = long) |
| ext_mode_i | input | 1 | Extended control mode active |
| trim_dis_i | input | 1 | Skip trim in on-command calibrations |
| cal_run_o | output | 1 | Calibration in progress |
| trim_phase_o | output | 1 | Termination-trim phase active |
| dclk_en_o | output | 1 | Data clock forward enable |
| cal_bit_o | output | 1 | Calibration register bit readback |

## Verification
The timing results have these due points:
- The power-up start is due exactly after edge `DLY_SHORT` or `DLY_LONG` following reset release.
- A pin trigger lands `HIGH_MIN`+2 edges after the first high sample: two synchroniser stages, then the qualifier register, then the phase register.
- A register write shows in `cal_bit_o` one edge later, and `cal_run_o` rises one edge after that.

The bench checks each of these on both sides of the due edge, sampling at the falling clock edge. For patterns where exact placement does not matter (the qualification boundaries and the trim skip), the bench counts running and clock-stopped cycles over a fixed window and compares the totals with `TRIM_LEN`+`CAL_LEN`, `CAL_LEN` or zero.

// File: rtl/cal_seq_pkg.sv
package cal_seq_pkg;

  typedef enum logic [1:0] {
    PH_WAIT = 2'd0,
    PH_TRIM = 2'd1,
    PH_CAL  = 2'd2,
    PH_IDLE = 2'd3
  } cal_phase_e;

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/cal_pin_qual.sv
module cal_pin_qual #(
  parameter int unsigned LOW_MIN     = 64,
  parameter int unsigned HIGH_MIN    = 64,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic fire_o
);
  localparam int unsigned LO_W = $clog2(LOW_MIN + 1);
  localparam int unsigned HI_W = $clog2(HIGH_MIN + 1);
  localparam logic [LO_W-1:0] LO_MAX  = LO_W'(LOW_MIN);
  localparam logic [HI_W-1:0] HI_LAST = HI_W'(HIGH_MIN - 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   pin_s;
  logic                   prev_q;
  logic                   fire_q;
  logic [LO_W-1:0]        lo_cnt_q;
  logic [HI_W-1:0]        hi_cnt_q;

  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q[g] <= 1'b0;
        else         sync_q[g] <= pin_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q[g] <= 1'b0;
        else         sync_q[g] <= sync_q[g-1];
      end
    end
  end

  assign pin_s = sync_q[SYNC_STAGES-1];

  // low run restarts at every falling level; high run counts only once armed
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q   <= 1'b0;
      fire_q   <= 1'b0;
      lo_cnt_q <= '0;
      hi_cnt_q <= '0;
    end else begin
      prev_q <= pin_s;
      fire_q <= 1'b0;
      if (!pin_s) begin
        hi_cnt_q <= '0;
        if (prev_q)                   lo_cnt_q <= LO_W'(1);
        else if (lo_cnt_q != LO_MAX)  lo_cnt_q <= lo_cnt_q + 1'b1;
      end else if (lo_cnt_q == LO_MAX) begin
        if (hi_cnt_q == HI_LAST) begin
          fire_q   <= 1'b1;
          lo_cnt_q <= '0;
          hi_cnt_q <= '0;
        end else begin
          hi_cnt_q <= hi_cnt_q + 1'b1;
        end
      end
    end
  end

  assign fire_o = fire_q;

endmodule

// File: rtl/cal_req_reg.sv
module cal_req_reg #(
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned CAL_ADDR = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              cal_i,
  input  logic              accept_i,
  input  logic              start_i,
  output logic              bit_o
);
  localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(CAL_ADDR);

  logic bit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                           bit_q <= 1'b0;
    else if (start_i)                                      bit_q <= 1'b0;
    else if (we_i && accept_i && addr_i == MY_ADDR && cal_i) bit_q <= 1'b1;
  end

  assign bit_o = bit_q;

endmodule

// File: rtl/cal_phase_ctl.sv
module cal_phase_ctl
  import cal_seq_pkg::*;
#(
  parameter int unsigned DLY_SHORT = 1024,
  parameter int unsigned DLY_LONG  = 16777216,
  parameter int unsigned TRIM_LEN  = 256,
  parameter int unsigned CAL_LEN   = 1400
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       dly_long_i,
  input  logic       req_i,
  input  logic       trim_dis_i,
  output cal_phase_e phase_o,
  output logic       start_o
);
  localparam int unsigned LEN_MAX = max2(max2(DLY_SHORT, DLY_LONG), max2(TRIM_LEN, CAL_LEN));
  localparam int unsigned CNT_W   = $clog2(LEN_MAX + 1);
  localparam logic [CNT_W-1:0] SHORT_LAST = CNT_W'(DLY_SHORT - 1);
  localparam logic [CNT_W-1:0] LONG_LAST  = CNT_W'(DLY_LONG - 1);
  localparam logic [CNT_W-1:0] TRIM_LAST  = CNT_W'(TRIM_LEN - 1);
  localparam logic [CNT_W-1:0] CAL_LAST   = CNT_W'(CAL_LEN - 1);

  cal_phase_e       phase_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] dly_last;

  assign dly_last = dly_long_i ? LONG_LAST : SHORT_LAST;
  assign start_o  = (phase_q == PH_IDLE) && req_i;

  // one counter serves the power-up wait and both phases
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_WAIT;
      cnt_q   <= '0;
    end else begin
      unique case (phase_q)
        PH_WAIT: begin
          if (cnt_q >= dly_last) begin
            phase_q <= PH_TRIM;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        PH_TRIM: begin
          if (cnt_q == TRIM_LAST) begin
            phase_q <= PH_CAL;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        PH_CAL: begin
          if (cnt_q == CAL_LAST) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        PH_IDLE: begin
          cnt_q <= '0;
          if (req_i) phase_q <= trim_dis_i ? PH_CAL : PH_TRIM;
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign phase_o = phase_q;

endmodule

// File: rtl/cal_sequencer.sv
module cal_sequencer
  import cal_seq_pkg::*;
#(
  parameter int unsigned LOW_MIN     = 64,
  parameter int unsigned HIGH_MIN    = 64,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned DLY_SHORT   = 1024,
  parameter int unsigned DLY_LONG    = 16777216,
  parameter int unsigned TRIM_LEN    = 256,
  parameter int unsigned CAL_LEN     = 1400,
  parameter int unsigned ADDR_W      = 4,
  parameter int unsigned CAL_ADDR    = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cal_pin_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic              reg_cal_i,
  input  logic              dly_sel_i,
  input  logic              ext_mode_i,
  input  logic              trim_dis_i,
  output logic              cal_run_o,
  output logic              trim_phase_o,
  output logic              dclk_en_o,
  output logic              cal_bit_o
);
  cal_phase_e phase;
  logic       pin_fire;
  logic       bit_q;
  logic       start;
  logic       dly_long;

  assign dly_long = dly_sel_i && !ext_mode_i;

  cal_pin_qual #(
    .LOW_MIN    (LOW_MIN),
    .HIGH_MIN   (HIGH_MIN),
    .SYNC_STAGES(SYNC_STAGES)
  ) i_pin_qual (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .pin_i (cal_pin_i),
    .fire_o(pin_fire)
  );

  cal_req_reg #(
    .ADDR_W  (ADDR_W),
    .CAL_ADDR(CAL_ADDR)
  ) i_req_reg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .addr_i  (reg_addr_i),
    .cal_i   (reg_cal_i),
    .accept_i(phase == PH_IDLE),
    .start_i (start),
    .bit_o   (bit_q)
  );

  cal_phase_ctl #(
    .DLY_SHORT(DLY_SHORT),
    .DLY_LONG (DLY_LONG),
    .TRIM_LEN (TRIM_LEN),
    .CAL_LEN  (CAL_LEN)
  ) i_phase_ctl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .dly_long_i(dly_long),
    .req_i     (pin_fire || bit_q),
    .trim_dis_i(trim_dis_i),
    .phase_o   (phase),
    .start_o   (start)
  );

  assign cal_run_o    = (phase == PH_TRIM) || (phase == PH_CAL);
  assign trim_phase_o = (phase == PH_TRIM);
  assign dclk_en_o    = (phase != PH_TRIM);
  assign cal_bit_o    = bit_q;

endmodule

// File: rtl/cal_sequencer_chk.sv
module cal_sequencer_chk #(
  parameter int unsigned TRIM_LEN = 256,
  parameter int unsigned CAL_LEN  = 1400
) (
  input logic clk_i,
  input logic rst_ni,
  input logic trim_dis_i,
  input logic cal_run_o,
  input logic trim_phase_o,
  input logic dclk_en_o,
  input logic cal_bit_o
);
  localparam int unsigned LEN_W = $clog2(TRIM_LEN + CAL_LEN + 1) + 1;

  logic             run_q;
  logic             done_q;
  logic             td_q;
  logic [LEN_W-1:0] run_len_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q     <= 1'b0;
      done_q    <= 1'b0;
      td_q      <= 1'b0;
      run_len_q <= '0;
    end else begin
      run_q     <= cal_run_o;
      td_q      <= trim_dis_i;
      run_len_q <= cal_run_o ? run_len_q + 1'b1 : '0;
      if (run_q && !cal_run_o) done_q <= 1'b1;
    end
  end

  AST_TRIM_INSIDE_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trim_phase_o |-> cal_run_o); // R6

  AST_DCLK_ON_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cal_run_o |-> dclk_en_o); // R6

  AST_BIT_STARTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cal_bit_o |=> cal_run_o); // R2

  AST_BIT_SELF_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cal_bit_o |=> !cal_bit_o); // R9

  AST_NO_BIT_WHILE_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && cal_run_o) |-> !cal_bit_o); // R10

  AST_RUN_LENGTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && !cal_run_o) |->
      (run_len_q == LEN_W'(TRIM_LEN + CAL_LEN) || run_len_q == LEN_W'(CAL_LEN))); // R3

  AST_PWRUP_TRIMS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!done_q && !run_q && cal_run_o) |-> trim_phase_o); // R8

  AST_TRIM_SKIPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q && !run_q && cal_run_o && td_q) |-> (!trim_phase_o && dclk_en_o)); // R7

endmodule

bind cal_sequencer cal_sequencer_chk #(
  .TRIM_LEN(TRIM_LEN),
  .CAL_LEN (CAL_LEN)
) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .trim_dis_i  (trim_dis_i),
  .cal_run_o   (cal_run_o),
  .trim_phase_o(trim_phase_o),
  .dclk_en_o   (dclk_en_o),
  .cal_bit_o   (cal_bit_o)
);

// File: tb/test_cal_sequencer.sv
module test_cal_sequencer;
  localparam int LOW_MIN = 4;
  localparam int HIGH_MIN = 3;
  localparam int DLY_SHORT = 5;
  localparam int DLY_LONG = 12;
  localparam int TRIM_LEN = 6;
  localparam int CAL_LEN = 10;
  localparam int ADDR_W = 4;

  typedef struct packed {
    logic [7:0] lo;
    logic [7:0] hi;
    logic       td;
    logic [7:0] run;
    logic [7:0] off;
  } vec_t;

  // low cycles, high cycles, trim disable, expected run cycles, expected clock-off cycles
  localparam vec_t VECS [6] = '{
    '{8'd4,  8'd3, 1'b0, 8'd16, 8'd6},
    '{8'd3,  8'd3, 1'b0, 8'd0,  8'd0},
    '{8'd4,  8'd2, 1'b0, 8'd0,  8'd0},
    '{8'd8,  8'd8, 1'b1, 8'd10, 8'd0},
    '{8'd4,  8'd3, 1'b1, 8'd10, 8'd0},
    '{8'd10, 8'd5, 1'b0, 8'd16, 8'd6}
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic cal_pin = 1'b0;
  logic reg_we = 1'b0;
  logic [ADDR_W-1:0] reg_addr = '0;
  logic reg_cal = 1'b0;
  logic dly_sel = 1'b0;
  logic ext_mode = 1'b0;
  logic trim_dis = 1'b0;
  logic cal_run, trim_phase, dclk_en, cal_bit;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  cal_sequencer #(
    .LOW_MIN(LOW_MIN), .HIGH_MIN(HIGH_MIN), .SYNC_STAGES(2),
    .DLY_SHORT(DLY_SHORT), .DLY_LONG(DLY_LONG),
    .TRIM_LEN(TRIM_LEN), .CAL_LEN(CAL_LEN),
    .ADDR_W(ADDR_W), .CAL_ADDR(0)
  ) i_cal_sequencer (
    .clk_i(clk), .rst_ni(rst_ni), .cal_pin_i(cal_pin),
    .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_cal_i(reg_cal),
    .dly_sel_i(dly_sel), .ext_mode_i(ext_mode), .trim_dis_i(trim_dis),
    .cal_run_o(cal_run), .trim_phase_o(trim_phase),
    .dclk_en_o(dclk_en), .cal_bit_o(cal_bit)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(input logic ds, input logic em, input logic td);
    @(negedge clk);
    rst_ni = 1'b0; dly_sel = ds; ext_mode = em; trim_dis = td; cal_pin = 1'b0;
    step(2);
    rst_ni = 1'b1;
  endtask

  // pre-high, low run, high run, then low, counting running and clock-off cycles
  task automatic pin_pulse(input int lo, input int hi, input int tail,
                           output int run_n, output int off_n);
    run_n = 0; off_n = 0;
    cal_pin = 1'b1;
    step(1);
    cal_pin = 1'b0;
    step(lo);
    cal_pin = 1'b1;
    for (int i = 0; i < hi; i++) begin
      step(1);
      run_n += int'(cal_run); off_n += int'(!dclk_en);
    end
    cal_pin = 1'b0;
    for (int i = 0; i < tail; i++) begin
      step(1);
      run_n += int'(cal_run); off_n += int'(!dclk_en);
    end
  endtask

  task automatic reg_write(input logic [ADDR_W-1:0] a);
    reg_we = 1'b1; reg_addr = a; reg_cal = 1'b1;
    step(1);
    reg_we = 1'b0; reg_cal = 1'b0;
  endtask

  initial begin
    int rn, on;

    // R11 reset state
    step(1);
    #1;
    chk("R11 run in reset", int'(cal_run), 0);
    chk("R11 trim in reset", int'(trim_phase), 0);
    chk("R11 dclk in reset", int'(dclk_en), 1);
    chk("R11 bit in reset", int'(cal_bit), 0);

    // R4 short delay, R6 trim window, R3 run length
    do_reset(1'b0, 1'b0, 1'b0);
    step(DLY_SHORT - 1);
    chk("R4 short not yet", int'(cal_run), 0);
    step(1);
    chk("R4 short started", int'(cal_run), 1);
    chk("R6 trim at start", int'(trim_phase), 1);
    chk("R6 dclk stopped", int'(dclk_en), 0);
    step(TRIM_LEN - 1);
    chk("R6 trim last cycle", int'(trim_phase), 1);
    step(1);
    chk("R6 trim over", int'(trim_phase), 0);
    chk("R6 dclk back", int'(dclk_en), 1);
    chk("R3 run in core", int'(cal_run), 1);
    step(CAL_LEN - 1);
    chk("R3 run last cycle", int'(cal_run), 1);
    step(1);
    chk("R3 run ended", int'(cal_run), 0);

    // R4 long delay
    do_reset(1'b1, 1'b0, 1'b0);
    step(DLY_LONG - 1);
    chk("R4 long not yet", int'(cal_run), 0);
    step(1);
    chk("R4 long started", int'(cal_run), 1);
    step(TRIM_LEN + CAL_LEN + 2);

    // R5 extended mode forces short delay
    do_reset(1'b1, 1'b1, 1'b0);
    step(DLY_SHORT - 1);
    chk("R5 ext not yet", int'(cal_run), 0);
    step(1);
    chk("R5 ext short start", int'(cal_run), 1);
    step(TRIM_LEN + CAL_LEN + 2);

    // R8 power-up trims despite trim disable
    do_reset(1'b0, 1'b0, 1'b1);
    step(DLY_SHORT);
    chk("R8 pwrup trim", int'(trim_phase), 1);
    step(TRIM_LEN + CAL_LEN + 2);
    chk("R8 idle after", int'(cal_run), 0);

    // R1 R3 R6 R7 pin pattern table
    foreach (VECS[v]) begin
      trim_dis = VECS[v].td;
      pin_pulse(int'(VECS[v].lo), int'(VECS[v].hi), 30, rn, on);
      chk($sformatf("R1 R3 vec%0d run cycles", v), rn, int'(VECS[v].run));
      chk($sformatf("R6 R7 vec%0d dclk off cycles", v), on, int'(VECS[v].off));
    end
    trim_dis = 1'b0;

    // R1 exact latency
    step(LOW_MIN + 4);
    cal_pin = 1'b1;
    step(HIGH_MIN + 2);
    chk("R1 pin not yet", int'(cal_run), 0);
    step(1);
    chk("R1 pin started", int'(cal_run), 1);
    cal_pin = 1'b0;
    step(TRIM_LEN + CAL_LEN + 2);

    // R2 R9 register trigger
    reg_write('0);
    chk("R2 bit set", int'(cal_bit), 1);
    chk("R2 not started yet", int'(cal_run), 0);
    step(1);
    chk("R9 bit cleared", int'(cal_bit), 0);
    chk("R2 started", int'(cal_run), 1);
    step(TRIM_LEN + CAL_LEN + 2);

    // R2 other address ignored
    reg_write(4'd1);
    chk("R2 other addr bit", int'(cal_bit), 0);
    step(3);
    chk("R2 other addr no run", int'(cal_run), 0);

    // R10 register write during run
    reg_write('0);
    step(3);
    reg_write('0);
    chk("R10 bit stays clear", int'(cal_bit), 0);
    step(TRIM_LEN + CAL_LEN);
    rn = 0;
    for (int i = 0; i < 12; i++) begin
      step(1);
      rn += int'(cal_run);
    end
    chk("R10 no start after reg", rn, 0);

    // R10 pin pulse during run
    reg_write('0);
    step(1);
    pin_pulse(5, 4, 30, rn, on);
    rn = 0;
    for (int i = 0; i < 12; i++) begin
      step(1);
      rn += int'(cal_run);
    end
    chk("R10 no start after pin", rn, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual 1 expected 0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule